// File: doc/BRIEF.md
# Fixed-Latency Timing Token Channel

This block carries timing tokens between two units of a cycle-level model. Each token holds the data signals that crossed one link of the modelled system during one modelled cycle, together with a data-enable bit. When that bit is clear, the token stands for a modelled cycle in which nothing was sent. A producer unit pushes one token for each modelled cycle it fires. A consumer unit pops one token for each of its own firings. Neither side depends on how many host clock cycles a firing takes.

The link being modelled has a fixed latency of `LATENCY` modelled cycles. Reset therefore does not leave the queue empty. It leaves `LATENCY` placeholder tokens in the queue, each carrying the `RESET_DATA` payload with the data-enable bit clear. As a result, the consumer's first `LATENCY` firings see those placeholders, and the token pushed in producer firing n reaches the consumer at consumer firing n + `LATENCY`. The storage depth `DEPTH` is at least `LATENCY`+1, so the producer can run ahead of the consumer by `DEPTH`-`LATENCY` firings.

Top module: `token_channel`

## Requirements
- R1: After reset, `not_empty_o` is 1, `not_full_o` is 1, and the head token (`first_vld_o`, `first_data_o`) is the placeholder: `first_vld_o`=0 and `first_data_o`=`RESET_DATA`.
- R2: The first `LATENCY` tokens popped after reset are all placeholders (data-enable 0, payload `RESET_DATA`). After they are popped with no push, `not_empty_o` is 0.
- R3: Tokens leave in the order they were pushed, each keeping its payload and data-enable bit. The token from push number n (counting from 0 after reset) is the head at pop number n+`LATENCY`.
- R4: `not_full_o` is 0 exactly when `DEPTH` tokens are held. With the default `DEPTH`=`LATENCY`+1, a single push with no pop after reset makes the channel full.
- R5: A push (`enq_en_i`=1) while `not_full_o` is 0 and `deq_i` is 0 is ignored. The pushed token never appears, and the occupancy is unchanged.
- R6: A pop (`deq_i`=1) while `not_empty_o` is 0 is ignored. A later push becomes the head unchanged.
- R7: A push and a pop in the same cycle on a full channel are both accepted. The channel stays full, and the pushed token comes out after the tokens already held.
- R8: A push and a pop in the same cycle on a partly filled channel keep the occupancy unchanged. `not_full_o` and `not_empty_o` stay at 1 throughout a lock-step stream.
- R9: A token pushed with data-enable 0 (no message) comes out with data-enable 0 and its payload as pushed. A token with data-enable 1 comes out with 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loads the placeholder tokens |
| not_full_o | output | 1 | Space for another token |
| enq_data_i | input | DATA_W | Payload of the pushed token |
| enq_vld_i | input | 1 | Data-enable bit of the pushed token (0 = no message) |
| enq_en_i | input | 1 | Push request |
| not_empty_o | output | 1 | A token is available at the head |
| first_data_o | output | DATA_W | Payload of the head token |
| first_vld_o | output | 1 | Data-enable bit of the head token |
| deq_i | input | 1 | Pop request |

## Verification
The case that is hardest to reach from the ports is a simultaneous push and pop on a full channel. Reset leaves the channel holding `LATENCY` tokens, so filling it takes exactly `DEPTH`-`LATENCY` pushes with no pop. The stimulus makes those pushes and then drives a push and a pop in the same cycle. It then drains the channel and compares the whole order of tokens that come out. Ignored pushes and pops are caught the same way: the bench drains the channel and checks which tokens come out and when `not_empty_o` drops.

// File: rtl/tok_chan_pkg.sv
package tok_chan_pkg;
  // circular pointer advance
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  typedef struct packed {
    logic push;
    logic pop;
  } xfer_t;
endpackage

// File: rtl/tok_chan_ctrl.sv
module tok_chan_ctrl #(
  parameter int unsigned LATENCY = 3,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_i,
  input  logic             deq_i,
  output logic             push_o,
  output logic             pop_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             not_full_o,
  output logic             not_empty_o
);
  import tok_chan_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  xfer_t            xf;

  assign not_full_o  = (cnt_q != CNT_W'(DEPTH));
  assign not_empty_o = (cnt_q != '0);

  // full channel still accepts a push paired with a pop
  always_comb begin
    xf.pop  = deq_i & not_empty_o;
    xf.push = enq_i & (not_full_o | xf.pop);
  end

  assign push_o   = xf.push;
  assign pop_o    = xf.pop;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(LATENCY);
      wr_q  <= PTR_W'(LATENCY % DEPTH);
      rd_q  <= '0;
    end else begin
      if (xf.push) wr_q <= PTR_W'(wrap_inc(32'(wr_q), DEPTH));
      if (xf.pop)  rd_q <= PTR_W'(wrap_inc(32'(rd_q), DEPTH));
      case (xf)
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  initial a_r4_depth_cfg: assert (DEPTH >= LATENCY + 1);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r5_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_full_o && enq_i && !deq_i) |=> $stable(cnt_q) && $stable(wr_q));

  a_r6_empty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_o && deq_i && !enq_i) |=> (cnt_q == '0) && $stable(rd_q));

  a_r7_full_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_full_o && enq_i && deq_i) |=> !not_full_o);
endmodule

// File: rtl/tok_chan_store.sv
module tok_chan_store #(
  parameter int unsigned            TOK_W = 9,
  parameter int unsigned            DEPTH = 4,
  parameter logic [TOK_W-1:0]       INIT  = '0,
  localparam int unsigned           PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [TOK_W-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [TOK_W-1:0] rdata_o
);
  logic [TOK_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem[i] <= INIT;
      else if (we_i && waddr_i == PTR_W'(i))   mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/token_channel.sv
module token_channel #(
  parameter int unsigned       DATA_W     = 8,
  parameter int unsigned       LATENCY    = 3,
  parameter int unsigned       DEPTH      = LATENCY + 1,
  parameter logic [DATA_W-1:0] RESET_DATA = 8'hA5,
  localparam int unsigned      TOK_W      = DATA_W + 1,
  localparam int unsigned      PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              not_full_o,
  input  logic [DATA_W-1:0] enq_data_i,
  input  logic              enq_vld_i,
  input  logic              enq_en_i,
  output logic              not_empty_o,
  output logic [DATA_W-1:0] first_data_o,
  output logic              first_vld_o,
  input  logic              deq_i
);
  logic             push, pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [TOK_W-1:0] head;

  tok_chan_ctrl #(.LATENCY(LATENCY), .DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .enq_i(enq_en_i), .deq_i(deq_i),
    .push_o(push), .pop_o(pop),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .not_full_o(not_full_o), .not_empty_o(not_empty_o)
  );

  // placeholder token: data-enable clear, reset payload
  tok_chan_store #(.TOK_W(TOK_W), .DEPTH(DEPTH), .INIT({1'b0, RESET_DATA})) u_store (
    .clk_i, .rst_ni,
    .we_i(push), .waddr_i(wr_ptr), .wdata_i({enq_vld_i, enq_data_i}),
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  assign first_vld_o  = head[DATA_W];
  assign first_data_o = head[DATA_W-1:0];

  a_r3_pop_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push) |=> not_full_o);
endmodule

// File: tb/token_channel_tb.sv
module token_channel_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned L  = 3;
  localparam logic [7:0]  RD = 8'hA5;

  logic clk = 0, rst_ni = 0;
  logic not_full, not_empty, first_vld, enq_vld = 0, enq_en = 0, deq = 0;
  logic [DW-1:0] enq_data = '0, first_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  token_channel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .not_full_o(not_full),
    .enq_data_i(enq_data), .enq_vld_i(enq_vld), .enq_en_i(enq_en),
    .not_empty_o(not_empty), .first_data_o(first_data),
    .first_vld_o(first_vld), .deq_i(deq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    enq_en = 0; deq = 0; enq_vld = 0; enq_data = '0;
    rst_ni = 0;
    #7;
    @(negedge clk); rst_ni = 1; #1;
  endtask

  // one host cycle with given inputs; returns after the edge
  task automatic step(logic e, logic v, logic [7:0] d, logic q);
    enq_en = e; enq_vld = v; enq_data = d; deq = q;
    @(posedge clk); #1;
    enq_en = 0; deq = 0;
  endtask

  task automatic chk_head(string req, logic v, logic [7:0] d);
    chk({req, " head_vld"}, first_vld, v);
    chk({req, " head_data"}, first_data, d);
    chk({req, " not_empty"}, not_empty, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 not_empty", not_empty, 1);
    chk("R1 not_full", not_full, 1);
    chk("R1 head_vld", first_vld, 0);
    chk("R1 head_data", first_data, RD);
  endtask

  task automatic t_preload_and_empty();
    do_reset();
    for (int i = 0; i < L; i++) begin
      chk_head("R2", 0, RD);
      step(0, 0, 0, 1);
    end
    chk("R2 empty after drain", not_empty, 0);
    step(0, 0, 0, 1);                   // R6 pop on empty
    chk("R6 still empty", not_empty, 0);
    chk("R6 not_full", not_full, 1);
    step(1, 1, 8'h3C, 0);
    chk_head("R6", 1, 8'h3C);
    step(0, 0, 0, 1);
    chk("R6 single token", not_empty, 0);
  endtask

  task automatic t_full_ignore();
    do_reset();
    step(1, 1, 8'h11, 0);
    chk("R4 full after one push", not_full, 0);
    step(1, 1, 8'h22, 0);               // R5 ignored push
    chk("R5 still full", not_full, 0);
    for (int i = 0; i < L; i++) begin
      chk_head("R5", 0, RD);
      step(0, 0, 0, 1);
    end
    chk_head("R5", 1, 8'h11);
    step(0, 0, 0, 1);
    chk("R5 dropped token absent", not_empty, 0);
  endtask

  task automatic t_full_swap();
    do_reset();
    step(1, 0, 8'h44, 0);
    chk("R7 full", not_full, 0);
    step(1, 1, 8'h55, 1);
    chk("R7 still full", not_full, 0);
    for (int i = 0; i < L - 1; i++) begin
      chk_head("R7", 0, RD);
      step(0, 0, 0, 1);
    end
    chk_head("R7 R9", 0, 8'h44);
    step(0, 0, 0, 1);
    chk_head("R7", 1, 8'h55);
    step(0, 0, 0, 1);
    chk("R7 drained", not_empty, 0);
  endtask

  task automatic t_stream();
    do_reset();
    for (int k = 0; k < 10; k++) begin
      if (k < L) chk_head("R3 preload", 0, RD);
      else       chk_head("R3 R9 stream", 1'((k - L) % 2), 8'(8'h10 + k - L));
      chk("R8 not_full", not_full, 1);
      step(1, 1'(k % 2), 8'(8'h10 + k), 1);
    end
  endtask

  initial begin
    t_reset();
    t_preload_and_empty();
    t_full_ignore();
    t_full_swap();
    t_stream();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule